// File: doc/BRIEF.md
# Timer-Paced JTAG Shift Engine

This block drives the TCK, TMS and TDI pins of a target test access port and samples its TDO pin. Its main operation moves the TAP from Run-Test-Idle through the instruction-register or data-register scan path, shifts a programmable number of data bits plus a fixed group of status bits, and walks back to Run-Test-Idle. The status bits leave the target first and are returned in their own register, beside the captured data.

Every TCK edge, rising or falling, is held back until a reloadable overflow timer wraps. The requester therefore chooses a TCK rate that stays below one eighth of the target clock. The timer counts either 16 bits, reloaded from a high and a low byte, or 8 bits, reloaded from the low byte alone. The block also runs a TAP reset walk, a single bare TCK pulse, a direct write of TMS and TDI, and a TDO read. One command is taken at a time through a valid/ready handshake, and each command ends with a one-cycle completion pulse.

Top module: `jtag_shift_engine`

## Requirements
- R1: After reset, TCK, TMS, TDI, done, rsp_status, rsp_data and rsp_tdo are all 0 and cmd_ready is 1. TCK stays low whenever the block is idle.
- R2: With tmr_mode = 0, consecutive TCK edges within an operation are exactly 65536 - {tmr_hi,tmr_lo} clock cycles apart, and the first rising edge follows acceptance by the same count.
- R3: With tmr_mode = 1, the TCK edge spacing is 256 - tmr_lo cycles, and tmr_hi has no effect.
- R4: Shift (cmd_op = 0) with cmd_ir = 0 drives TMS 1,0,0 from Run-Test-Idle, then STAT_W + length clocks in Shift-DR with TMS high only on the last, then TMS 1,0, ending in Run-Test-Idle.
- R5: Shift with cmd_ir = 1 drives TMS 1,1,0,0 to reach Shift-IR, then follows the same shift and exit pattern as R4.
- R6: During the shift clocks TDI carries cmd_data least significant bit first for the first `length` clocks, then 0 for the remaining STAT_W clocks.
- R7: The first STAT_W TDO bits sampled in the shift state go to rsp_status, bit 0 first. The next `length` bits go to rsp_data from bit 0 upward, and higher rsp_data bits read 0. The response registers change only in the cycle that done is high.
- R8: A cmd_len above DATA_W is treated as DATA_W.
- R9: TMS and TDI change only together with, or while, TCK is low (the falling edge). TDO is sampled at the rising edge.
- R10: TAP reset (cmd_op = 1) gives six TCK clocks: five with TMS high and one with TMS low. The TAP ends in Run-Test-Idle from any state.
- R11: Pulse (cmd_op = 2) gives exactly one TCK clock and leaves TMS and TDI unchanged.
- R12: Pin write (cmd_op = 3) sets TMS to cmd_data[1] and TDI to cmd_data[0] with no TCK edge. It and codes 5 to 7 raise done in the cycle after acceptance. Codes 5 to 7 change no pin.
- R13: TDO read (cmd_op = 4) places the TDO level in rsp_tdo, and done rises in the cycle after acceptance.
- R14: A command is taken only when cmd_valid and cmd_ready are both high. cmd_ready is low from the cycle after a timed command is accepted until the cycle in which done is high. In that cycle a waiting command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 3 | Operation code (0 shift, 1 TAP reset, 2 pulse, 3 pin write, 4 TDO read) |
| cmd_ir | input | 1 | Shift target: 1 instruction register, 0 data register |
| cmd_len | input | LEN_W | Number of data bits to shift, status bits not included |
| cmd_data | input | DATA_W | Shift data, or pin values for a pin write |
| tmr_mode | input | 1 | Pacing timer width select: 0 sixteen bits, 1 eight bits |
| tmr_hi | input | 8 | Pacing timer reload, high byte |
| tmr_lo | input | 8 | Pacing timer reload, low byte |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | STAT_W | Status bits from the last shift |
| rsp_data | output | DATA_W | Data bits from the last shift |
| rsp_tdo | output | 1 | TDO level from the last read |

## Verification
The final falling TCK edge of one operation and the acceptance of the next command can fall in the same cycle. In that cycle done pulses, the response registers load, and cmd_ready is already high. The bench provokes this by holding cmd_valid high with a TAP reset command for the whole of a shift. It then judges that the shift response is correct when done is high, that cmd_ready drops on the very next cycle, and that the target model sees exactly six further clocks and passes through Test-Logic-Reset to Run-Test-Idle.

// File: rtl/jse_pkg.sv
package jse_pkg;

    localparam int JSE_BYTE_W   = 8;
    localparam int JSE_PRE_DR   = 3;
    localparam int JSE_PRE_IR   = 4;
    localparam int JSE_POST     = 2;
    localparam int JSE_RST_CLKS = 6;

    typedef enum logic [2:0] {
        OP_SHIFT    = 3'd0,
        OP_TAP_RST  = 3'd1,
        OP_PULSE    = 3'd2,
        OP_SET_PINS = 3'd3,
        OP_READ_TDO = 3'd4
    } jse_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } jse_state_e;

    typedef struct packed {
        logic tms;
        logic tdi;
    } jse_pins_t;

    function automatic logic jse_is_timed(input logic [2:0] op);
        return (op == OP_SHIFT) || (op == OP_TAP_RST) || (op == OP_PULSE);
    endfunction

endpackage

// File: rtl/jse_pace_timer.sv
module jse_pace_timer
    import jse_pkg::*;
#(
    parameter int BYTE_W = JSE_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic              mode,
    input  logic [BYTE_W-1:0] rel_hi,
    input  logic [BYTE_W-1:0] rel_lo,
    output logic              tick
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;
    logic             wrap;

    always_comb begin
        reload = mode ? {{BYTE_W{1'b0}}, rel_lo} : {rel_hi, rel_lo};
        wrap   = mode ? (&cnt_q[BYTE_W-1:0]) : (&cnt_q);
        tick   = run && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= reload;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/jse_bit_plan.sv
module jse_bit_plan
    import jse_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STAT_W = 4,
    parameter int LEN_W  = 5,
    parameter int STEP_W = 5
) (
    input  logic [2:0]        op,
    input  logic              ir,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] data,
    input  logic [STEP_W-1:0] step,
    input  jse_pins_t         cur,
    output jse_pins_t         nxt,
    output logic [STEP_W-1:0] total,
    output logic [STEP_W-1:0] pre,
    output logic [STEP_W-1:0] nbits
);
    logic [STEP_W-1:0] idx;
    logic [DATA_W-1:0] data_sh;

    always_comb begin
        pre     = ir ? STEP_W'(JSE_PRE_IR) : STEP_W'(JSE_PRE_DR);
        nbits   = STEP_W'(STAT_W) + STEP_W'(len);
        idx     = step - pre;
        data_sh = data >> idx;
        nxt     = cur;
        total   = STEP_W'(1);
        case (op)
            OP_SHIFT: begin
                total   = pre + nbits + STEP_W'(JSE_POST);
                nxt.tdi = 1'b0;
                if (step < pre) begin
                    nxt.tms = ir ? (step < STEP_W'(2)) : (step == '0);
                end else if (step < pre + nbits) begin
                    nxt.tms = (idx == nbits - STEP_W'(1));
                    if (idx < STEP_W'(len)) begin
                        nxt.tdi = data_sh[0];
                    end
                end else begin
                    nxt.tms = (step == pre + nbits);
                end
            end
            OP_TAP_RST: begin
                total   = STEP_W'(JSE_RST_CLKS);
                nxt.tms = (step < STEP_W'(JSE_RST_CLKS - 1));
            end
            default: begin
                total = STEP_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/jse_tdo_capture.sv
module jse_tdo_capture #(
    parameter int DATA_W = 16,
    parameter int STAT_W = 4,
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample_en,
    input  logic [STEP_W-1:0] idx,
    input  logic              tdo,
    input  logic              commit,
    output logic [STAT_W-1:0] status_o,
    output logic [DATA_W-1:0] data_o
);
    logic [STAT_W-1:0] acc_stat;
    logic [DATA_W-1:0] acc_data;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_stat <= '0;
            acc_data <= '0;
        end else if (sample_en) begin
            for (int s = 0; s < STAT_W; s++) begin
                if (idx == STEP_W'(s)) acc_stat[s] <= tdo;
            end
            for (int d = 0; d < DATA_W; d++) begin
                if (idx == STEP_W'(STAT_W + d)) acc_data[d] <= tdo;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            data_o   <= '0;
        end else if (commit) begin
            status_o <= acc_stat;
            data_o   <= acc_data;
        end
    end

endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
    import jse_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STAT_W = 4,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [2:0]            cmd_op,
    input  logic                  cmd_ir,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic [DATA_W-1:0]     cmd_data,
    input  logic                  tmr_mode,
    input  logic [JSE_BYTE_W-1:0] tmr_hi,
    input  logic [JSE_BYTE_W-1:0] tmr_lo,
    output logic                  tck,
    output logic                  tms,
    output logic                  tdi,
    input  logic                  tdo,
    output logic                  done,
    output logic [STAT_W-1:0]     rsp_status,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  rsp_tdo
);
    localparam int MAX_CLK = JSE_PRE_IR + STAT_W + DATA_W + JSE_POST;
    localparam int STEP_W  = $clog2(MAX_CLK + 1);

    jse_state_e        state_q;
    logic [2:0]        op_q;
    logic              ir_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] data_q;
    logic [STEP_W-1:0] step_q, total_q, pre_q, nbits_q;
    jse_pins_t         pins_q;
    logic              tck_q, done_q, rsp_tdo_q;

    logic [LEN_W-1:0]  len_c;
    logic              accept, start_timed, pace_tick, last_clk;
    logic              in_window, sample_en, commit;
    logic [STEP_W-1:0] win_idx;

    logic [2:0]        p_op;
    logic              p_ir;
    logic [LEN_W-1:0]  p_len;
    logic [DATA_W-1:0] p_data;
    logic [STEP_W-1:0] p_step, p_total, p_pre, p_nbits;
    jse_pins_t         p_pins;

    assign cmd_ready   = (state_q == ST_IDLE);
    assign accept      = cmd_valid && cmd_ready;
    assign start_timed = accept && jse_is_timed(cmd_op);
    assign len_c       = (cmd_len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : cmd_len;
    assign last_clk    = (step_q == total_q - STEP_W'(1));
    assign in_window   = (op_q == OP_SHIFT) && (step_q >= pre_q) && (step_q < pre_q + nbits_q);
    assign win_idx     = step_q - pre_q;
    assign sample_en   = (state_q == ST_RISE) && pace_tick && in_window;
    assign commit      = (state_q == ST_FALL) && pace_tick && last_clk && (op_q == OP_SHIFT);

    always_comb begin
        if (state_q == ST_IDLE) begin
            p_op   = cmd_op;
            p_ir   = cmd_ir;
            p_len  = len_c;
            p_data = cmd_data;
            p_step = '0;
        end else begin
            p_op   = op_q;
            p_ir   = ir_q;
            p_len  = len_q;
            p_data = data_q;
            p_step = step_q + STEP_W'(1);
        end
    end

    jse_pace_timer #(.BYTE_W(JSE_BYTE_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (start_timed),
        .run     (state_q != ST_IDLE),
        .mode    (tmr_mode),
        .rel_hi  (tmr_hi),
        .rel_lo  (tmr_lo),
        .tick    (pace_tick)
    );

    jse_bit_plan #(
        .DATA_W(DATA_W), .STAT_W(STAT_W), .LEN_W(LEN_W), .STEP_W(STEP_W)
    ) u_plan (
        .op    (p_op),
        .ir    (p_ir),
        .len   (p_len),
        .data  (p_data),
        .step  (p_step),
        .cur   (pins_q),
        .nxt   (p_pins),
        .total (p_total),
        .pre   (p_pre),
        .nbits (p_nbits)
    );

    jse_tdo_capture #(
        .DATA_W(DATA_W), .STAT_W(STAT_W), .STEP_W(STEP_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_timed && (cmd_op == OP_SHIFT)),
        .sample_en (sample_en),
        .idx       (win_idx),
        .tdo       (tdo),
        .commit    (commit),
        .status_o  (rsp_status),
        .data_o    (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            ir_q      <= 1'b0;
            len_q     <= '0;
            data_q    <= '0;
            step_q    <= '0;
            total_q   <= '0;
            pre_q     <= '0;
            nbits_q   <= '0;
            pins_q    <= '0;
            tck_q     <= 1'b0;
            done_q    <= 1'b0;
            rsp_tdo_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (jse_is_timed(cmd_op)) begin
                            op_q    <= cmd_op;
                            ir_q    <= cmd_ir;
                            len_q   <= len_c;
                            data_q  <= cmd_data;
                            step_q  <= '0;
                            total_q <= p_total;
                            pre_q   <= p_pre;
                            nbits_q <= p_nbits;
                            pins_q  <= p_pins;
                            state_q <= ST_RISE;
                        end else begin
                            if (cmd_op == OP_SET_PINS) begin
                                pins_q.tms <= cmd_data[1];
                                pins_q.tdi <= cmd_data[0];
                            end
                            if (cmd_op == OP_READ_TDO) begin
                                rsp_tdo_q <= tdo;
                            end
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_RISE: begin
                    if (pace_tick) begin
                        tck_q   <= 1'b1;
                        state_q <= ST_FALL;
                    end
                end
                ST_FALL: begin
                    if (pace_tick) begin
                        tck_q <= 1'b0;
                        if (last_clk) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            step_q  <= step_q + STEP_W'(1);
                            pins_q  <= p_pins;
                            state_q <= ST_RISE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tck     = tck_q;
    assign tms     = pins_q.tms;
    assign tdi     = pins_q.tdi;
    assign done    = done_q;
    assign rsp_tdo = rsp_tdo_q;

endmodule

// File: rtl/jse_checker.sv
module jse_checker
    import jse_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int STAT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic              tck,
    input logic              tms,
    input logic              tdi,
    input logic              done,
    input logic [STAT_W-1:0] rsp_status,
    input logic [DATA_W-1:0] rsp_data,
    input logic              tick
);

    p_idle_tck_low_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !tck);

    p_edge_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(tck) |-> $past(tick));

    p_pins_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tms) || !$stable(tdi)) |-> !tck);

    p_rsp_on_done_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(rsp_status) || !$stable(rsp_data)) |-> done);

    p_pinwrite_quick_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == OP_SET_PINS) |=> (done && $stable(tck)));

    p_busy_after_accept_r14: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && jse_is_timed(cmd_op)) |=> !cmd_ready);

endmodule

bind jtag_shift_engine jse_checker #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_jse_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi),
    .done       (done),
    .rsp_status (rsp_status),
    .rsp_data   (rsp_data),
    .tick       (pace_tick)
);

// File: tb/tb_jtag_shift_engine.sv
`timescale 1ns/1ps
module tb_jtag_shift_engine;
    localparam int DW = 16;
    localparam int SW = 4;
    localparam int NV = 6;

    localparam bit         V_IR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [4:0] V_LEN  [NV] = '{5'd8, 5'd4, 5'd16, 5'd1, 5'd0, 5'd20};
    localparam logic [15:0] V_DAT [NV] = '{16'h00A5, 16'h000B, 16'hC3E1, 16'h0001, 16'hFFFF, 16'h8001};
    localparam logic [31:0] V_CAP [NV] = '{32'h1234_5679, 32'hABCD_EF01, 32'hFEDC_BA98,
                                           32'h0000_0017, 32'h0000_000A, 32'h5555_AAAA};
    localparam bit         V_MODE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [7:0] V_HI   [NV] = '{8'hFF, 8'h12, 8'hFF, 8'h00, 8'hFF, 8'hFF};
    localparam logic [7:0] V_LO   [NV] = '{8'hFD, 8'hFE, 8'hFA, 8'hFD, 8'hFE, 8'hFD};

    localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4, S_EX1DR = 5,
                   S_PAUDR = 6, S_EX2DR = 7, S_UPDDR = 8, S_SELIR = 9, S_CAPIR = 10,
                   S_SHIR = 11, S_EX1IR = 12, S_PAUIR = 13, S_EX2IR = 14, S_UPDIR = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic cmd_ir = 1'b0;
    logic [4:0] cmd_len = '0;
    logic [DW-1:0] cmd_data = '0;
    logic tmr_mode = 1'b0;
    logic [7:0] tmr_hi = 8'hFF, tmr_lo = 8'hFD;
    logic cmd_ready, tck, tms, tdi, tdo, done, rsp_tdo;
    logic [SW-1:0] rsp_status;
    logic [DW-1:0] rsp_data;

    int checks = 0, errors = 0;

    logic force_en = 1'b0, force_val = 1'b0, model_tdo = 1'b0;
    assign tdo = force_en ? force_val : model_tdo;

    jtag_shift_engine #(.DATA_W(DW), .STAT_W(SW)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_ir(cmd_ir), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .tmr_mode(tmr_mode), .tmr_hi(tmr_hi), .tmr_lo(tmr_lo),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .done(done),
        .rsp_status(rsp_status), .rsp_data(rsp_data), .rsp_tdo(rsp_tdo)
    );

    always #5 clk = ~clk;

    // Behavioural target TAP
    int m_state = S_TLR, m_cnt = 0, m_rises = 0;
    logic [31:0] m_sr = '0, m_log = '0, m_cap = '0;
    bit m_saw_ir = 0, m_saw_dr = 0, m_saw_tlr = 0;

    function automatic int tap_next(input int s, input logic t);
        case (s)
            S_TLR:   return t ? S_TLR   : S_RTI;
            S_RTI:   return t ? S_SELDR : S_RTI;
            S_SELDR: return t ? S_SELIR : S_CAPDR;
            S_CAPDR: return t ? S_EX1DR : S_SHDR;
            S_SHDR:  return t ? S_EX1DR : S_SHDR;
            S_EX1DR: return t ? S_UPDDR : S_PAUDR;
            S_PAUDR: return t ? S_EX2DR : S_PAUDR;
            S_EX2DR: return t ? S_UPDDR : S_SHDR;
            S_UPDDR: return t ? S_SELDR : S_RTI;
            S_SELIR: return t ? S_TLR   : S_CAPIR;
            S_CAPIR: return t ? S_EX1IR : S_SHIR;
            S_SHIR:  return t ? S_EX1IR : S_SHIR;
            S_EX1IR: return t ? S_UPDIR : S_PAUIR;
            S_PAUIR: return t ? S_EX2IR : S_PAUIR;
            S_EX2IR: return t ? S_UPDIR : S_SHIR;
            default: return t ? S_SELDR : S_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        m_rises++;
        if (m_state == S_CAPDR || m_state == S_CAPIR) m_sr = m_cap;
        if (m_state == S_SHDR || m_state == S_SHIR) begin
            m_log[m_cnt] = tdi;
            m_cnt++;
            m_sr = {tdi, m_sr[31:1]};
            if (m_state == S_SHIR) m_saw_ir = 1; else m_saw_dr = 1;
        end
        m_state = tap_next(m_state, tms);
        if (m_state == S_TLR) m_saw_tlr = 1;
    end

    always @(negedge tck) model_tdo = m_sr[0];

    // Edge spacing and pin timing monitor
    int cyc = 0, last_edge = 0, exp_p = 0, iv_err = 0, r9_err = 0;
    bit have_edge = 0;
    logic prev_tck = 1'b0, prev_tms = 1'b0, prev_tdi = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (tck !== prev_tck) begin
                if (have_edge && (cyc - last_edge) != exp_p) iv_err++;
                last_edge = cyc;
                have_edge = 1;
            end
            if ((tms !== prev_tms || tdi !== prev_tdi) && tck) r9_err++;
        end
        prev_tck = tck; prev_tms = tms; prev_tdi = tdi;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic ir, input logic [4:0] len,
                         input logic [15:0] data, output int lat);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ir = ir; cmd_len = len; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done) begin @(negedge clk); lat++; end
    endtask

    task automatic arm(input int p);
        have_edge = 0; iv_err = 0; exp_p = p;
        m_cnt = 0; m_log = '0; m_saw_ir = 0; m_saw_dr = 0; m_saw_tlr = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int lat, r0, eff, p;
        logic [31:0] mask;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tck", tck, 0); chk("R1 tms", tms, 0); chk("R1 tdi", tdi, 0);
        chk("R1 ready", cmd_ready, 1); chk("R1 done", done, 0);
        chk("R1 status", rsp_status, 0); chk("R1 data", rsp_data, 0); chk("R1 rsp_tdo", rsp_tdo, 0);

        // R10 TAP reset from Test-Logic-Reset
        arm(3); r0 = m_rises;
        issue(3'd1, 1'b0, 5'd0, 16'h0, lat);
        chk("R10 clocks", m_rises - r0, 6);
        chk("R10 end state", m_state, S_RTI);
        chk("R2 spacing reset", iv_err, 0);

        // R12 pin write
        r0 = m_rises;
        issue(3'd3, 1'b0, 5'd0, 16'h0001, lat);
        chk("R12 tms", tms, 0); chk("R12 tdi", tdi, 1);
        chk("R12 latency", lat, 1); chk("R12 no tck", m_rises - r0, 0);

        // R11 single pulse
        arm(3); r0 = m_rises;
        issue(3'd2, 1'b0, 5'd0, 16'h0, lat);
        chk("R11 one clock", m_rises - r0, 1);
        chk("R11 tms kept", tms, 0); chk("R11 tdi kept", tdi, 1);
        chk("R11 tck low", tck, 0); chk("R11 tap state", m_state, S_RTI);

        // R12 unused code 7
        r0 = m_rises;
        issue(3'd7, 1'b0, 5'd0, 16'h0002, lat);
        chk("R12 code7 latency", lat, 1); chk("R12 code7 tms", tms, 0);
        chk("R12 code7 tdi", tdi, 1); chk("R12 code7 tck", m_rises - r0, 0);

        // R13 TDO read
        force_en = 1'b1; force_val = 1'b1;
        issue(3'd4, 1'b0, 5'd0, 16'h0, lat);
        chk("R13 tdo high", rsp_tdo, 1); chk("R13 latency", lat, 1);
        force_val = 1'b0;
        issue(3'd4, 1'b0, 5'd0, 16'h0, lat);
        chk("R13 tdo low", rsp_tdo, 0);
        force_en = 1'b0;

        issue(3'd3, 1'b0, 5'd0, 16'h0002, lat);
        chk("R12 tms set", tms, 1); chk("R12 tdi clear", tdi, 0);
        issue(3'd3, 1'b0, 5'd0, 16'h0000, lat);

        // Shift vectors
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            tmr_mode = V_MODE[v]; tmr_hi = V_HI[v]; tmr_lo = V_LO[v];
            p = V_MODE[v] ? (256 - int'(V_LO[v])) : (65536 - int'({V_HI[v], V_LO[v]}));
            m_cap = V_CAP[v];
            arm(p);
            eff  = (V_LEN[v] > 5'd16) ? 16 : int'(V_LEN[v]);
            mask = (eff == 0) ? 32'h0 : ((32'h1 << eff) - 32'h1);
            issue(3'd0, V_IR[v], V_LEN[v], V_DAT[v], lat);
            chk(V_LEN[v] > 5'd16 ? "R8 clamp count" : (V_IR[v] ? "R5 shift count" : "R4 shift count"),
                m_cnt, SW + eff);
            chk(V_IR[v] ? "R5 ir path" : "R4 dr path", {m_saw_ir, m_saw_dr}, {V_IR[v], !V_IR[v]});
            chk(V_IR[v] ? "R5 end state" : "R4 end state", m_state, S_RTI);
            chk("R6 tdi stream", m_log, {16'h0, V_DAT[v]} & mask);
            chk("R7 status", rsp_status, V_CAP[v][3:0]);
            chk("R7 data", rsp_data, (V_CAP[v] >> SW) & mask);
            chk(V_MODE[v] ? "R3 spacing" : "R2 spacing", iv_err, 0);
        end

        // R14 back-to-back: reset waiting during a shift
        @(negedge clk);
        tmr_mode = 1'b1; tmr_hi = 8'h00; tmr_lo = 8'hFE;
        m_cap = 32'hF0F0_1234; arm(2);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_ir = 1'b0; cmd_len = 5'd8; cmd_data = 16'h005A;
        @(negedge clk);
        cmd_op = 3'd1;
        chk("R14 busy", cmd_ready, 0);
        while (!done) @(negedge clk);
        chk("R7 b2b data", rsp_data, 32'h23);
        chk("R7 b2b status", rsp_status, 32'h4);
        chk("R14 ready at done", cmd_ready, 1);
        chk("R4 b2b count", m_cnt, SW + 8);
        r0 = m_rises; m_saw_tlr = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R14 taken at done", cmd_ready, 0);
        while (!done) @(negedge clk);
        chk("R10 b2b clocks", m_rises - r0, 6);
        chk("R10 b2b passed reset", m_saw_tlr, 1);
        chk("R10 b2b end", m_state, S_RTI);
        chk("R9 pin timing", r9_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule